// File: doc/BRIEF.md
# Byte-coherent timer channel value register

This block holds the 16-bit value of one timer channel for a processor whose data bus is eight bits wide, so software reaches the value one byte at a time. A read of either byte captures the whole 16-bit value into a read latch. The byte read next then comes from that copy, so the two halves software assembles always belong to one value even while the live register changes between the two accesses.

Writes land in a two-byte staging buffer. A pair is complete once both bytes have been written, in either order. When the pair completes, the active register takes the staged value at a moment set by the channel mode and the timer clock selection: at once when no clock source is selected; at the next prescaler-end tick in output compare; at the counter rollover from its modulo value to zero in edge-aligned PWM. In input capture the register ignores bus writes and loads the free-running count on a capture strobe. Writing the channel control byte drops the read latch and abandons any half-written or waiting pair. Under debug freeze, reads see the live register, and a value write drops the read latch. Software can confirm a deferred update by reading both bytes back until they equal what it wrote.

Top module: `chanval_coherent`

## Requirements
- R1: After reset the channel value, the control byte (and so the mode), the read latch and the staging buffer are all zero. A read of the control byte returns 0.
- R2: Outside debug freeze, a value byte read with the latch empty returns the live byte and captures all 16 bits. Later value reads return bytes from the capture. The read of the byte other than the one that filled the latch empties it. Bus addresses: 0 is the value high byte, 1 is the value low byte, 2 is the control byte, and 3 reads 0.
- R3: A control byte write sets the mode from bits [1:0] (00 input capture, 01 or 11 output compare, 10 edge-aligned PWM), empties the read latch, and discards a half-written pair or a waiting staged value.
- R4: During debug freeze a value byte read returns the live register byte and leaves the read latch as it was. A value byte write during freeze empties the read latch.
- R5: In input capture mode, value byte writes change nothing. A capture strobe loads the counter value into the register. In other modes the strobe has no effect.
- R6: With clock select 00 in output compare or PWM mode, the byte write that completes a pair updates the register at the same clock edge.
- R7: In output compare mode with clock select not 00, a completed pair is copied at the first prescaler tick in a cycle after the completing write, and not before.
- R8: In PWM mode with clock select not 00, a completed pair is copied only in a cycle that has a prescaler tick and a counter equal to the modulo value.
- R9: A single byte write leaves the register unchanged. Pairs complete in either byte order. A byte write while a staged value waits cancels that value and starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 value high, 1 value low, 2 control, 3 unused |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational, 0 when not reading) |
| clk_src | input | 2 | Timer clock selection, 00 = no clock |
| pre_tick | input | 1 | Prescaler end, the counter advances this cycle |
| ctr_now | input | 16 | Free-running counter value |
| ctr_mod | input | 16 | Counter modulo value |
| dbg_freeze | input | 1 | Debug freeze active |
| cap_evt | input | 1 | Capture strobe from the edge detector |
| ch_val | output | 16 | Active channel value |
| ch_mode | output | 2 | Channel mode bits from the control byte |

## Verification
The bench targets the cycle that sees both a completing write and a prescaler tick. A design that commits there would update one tick too early in compare mode. It also checks that the latched byte survives a live update between the two reads. A design that skips the latch would return a torn value. A freeze read in the middle of a latched pair must leave the latch intact, and a freeze write must clear it. Mixing these up shows up as a wrong byte on the following normal read. Control writes and new byte writes that land on a waiting pair must cancel it, and a rollover tick with the counter short of the modulo must not commit in PWM. Otherwise the register changes at a tick where it has to hold.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

    typedef enum logic [1:0] {
        MD_CAPTURE  = 2'b00,
        MD_COMPARE  = 2'b01,
        MD_PWM      = 2'b10,
        MD_COMPARE2 = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        RA_VAL_HI = 2'd0,
        RA_VAL_LO = 2'd1,
        RA_CTRL   = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic rd_ctrl;
        logic wr_hi;
        logic wr_lo;
        logic wr_ctrl;
    } bus_op_t;

    function automatic bus_op_t decode_op(logic en, logic wr, logic [1:0] addr);
        bus_op_t   op;
        reg_addr_e a;
        a          = reg_addr_e'(addr);
        op.rd_hi   = en && !wr && (a == RA_VAL_HI);
        op.rd_lo   = en && !wr && (a == RA_VAL_LO);
        op.rd_ctrl = en && !wr && (a == RA_CTRL);
        op.wr_hi   = en &&  wr && (a == RA_VAL_HI);
        op.wr_lo   = en &&  wr && (a == RA_VAL_LO);
        op.wr_ctrl = en &&  wr && (a == RA_CTRL);
        return op;
    endfunction

    function automatic logic mode_takes_writes(chan_mode_e m);
        return m != MD_CAPTURE;
    endfunction

    function automatic logic mode_is_pwm(chan_mode_e m);
        return m == MD_PWM;
    endfunction

endpackage

// File: rtl/cvr_rdlatch.sv
module cvr_rdlatch #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic              freeze,
    input  logic              clear_req,
    input  logic [VAL_W-1:0]  live,
    output logic [BYTE_W-1:0] rd_byte
);

    logic             lat_v;
    logic             lat_hi_first;
    logic [VAL_W-1:0] lat_q;
    logic [BYTE_W-1:0] live_b;
    logic [BYTE_W-1:0] held_b;

    always_comb begin
        live_b  = rd_hi ? live[BYTE_W +: BYTE_W]  : live[0 +: BYTE_W];
        held_b  = rd_hi ? lat_q[BYTE_W +: BYTE_W] : lat_q[0 +: BYTE_W];
        rd_byte = (freeze || !lat_v) ? live_b : held_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_v        <= 1'b0;
            lat_hi_first <= 1'b0;
            lat_q        <= '0;
        end else if (clear_req) begin
            lat_v <= 1'b0;
        end else if ((rd_hi || rd_lo) && !freeze) begin
            if (!lat_v) begin
                lat_v        <= 1'b1;
                lat_hi_first <= rd_hi;
                lat_q        <= live;
            end else if (rd_hi != lat_hi_first) begin
                lat_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cvr_wbuf.sv
module cvr_wbuf
    import cvr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cancel,
    input  logic              immediate,
    input  logic              fire,
    output logic              commit,
    output logic [VAL_W-1:0]  commit_val
);

    logic [LANES-1:0] wr_lane;
    logic [LANES-1:0] have_q;
    logic             pend_q;
    logic             any_wr;
    logic             pair_done;

    assign wr_lane[LANE_HI] = wr_hi;
    assign wr_lane[LANE_LO] = wr_lo;
    assign any_wr           = |wr_lane;
    assign pair_done        = any_wr && ((have_q | wr_lane) == {LANES{1'b1}});

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] held;
        always_ff @(posedge clk) begin
            if (rst)             held <= '0;
            else if (wr_lane[g]) held <= wdata;
        end
        assign commit_val[g*BYTE_W +: BYTE_W] = wr_lane[g] ? wdata : held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= '0;
            pend_q <= 1'b0;
        end else if (cancel) begin
            have_q <= '0;
            pend_q <= 1'b0;
        end else if (any_wr) begin
            have_q <= pair_done ? '0 : (have_q | wr_lane);
            pend_q <= pair_done && !immediate;
        end else if (pend_q && fire) begin
            pend_q <= 1'b0;
        end
    end

    assign commit = !cancel &&
                    ((pair_done && immediate) || (pend_q && fire && !any_wr));

endmodule

// File: rtl/cvr_valreg.sv
module cvr_valreg
    import cvr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [VAL_W-1:0]  commit_val,
    input  logic              cap_evt,
    input  logic [VAL_W-1:0]  cap_val,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    output logic [VAL_W-1:0]  val_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output chan_mode_e        mode
);

    assign mode = chan_mode_e'(ctrl_q[1:0]);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                                val_q <= '0;
        else if (cap_evt && mode == MD_CAPTURE) val_q <= cap_val;
        else if (commit)                        val_q <= commit_val;
    end

endmodule

// File: rtl/chanval_coherent.sv
module chanval_coherent
    import cvr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [1:0]        clk_src,
    input  logic              pre_tick,
    input  logic [VAL_W-1:0]  ctr_now,
    input  logic [VAL_W-1:0]  ctr_mod,
    input  logic              dbg_freeze,
    input  logic              cap_evt,
    output logic [VAL_W-1:0]  ch_val,
    output logic [1:0]        ch_mode
);

    bus_op_t           op;
    chan_mode_e        mode;
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] lat_byte;
    logic              wr_ok;
    logic              fire;
    logic              commit;
    logic [VAL_W-1:0]  commit_val;
    logic              lat_clear;

    assign op        = decode_op(bus_en, bus_wr, bus_addr);
    assign wr_ok     = mode_takes_writes(mode);
    assign fire      = mode_is_pwm(mode) ? (pre_tick && (ctr_now == ctr_mod)) : pre_tick;
    assign lat_clear = op.wr_ctrl || (dbg_freeze && (op.wr_hi || op.wr_lo));
    assign ch_mode   = ctrl_q[1:0];

    cvr_rdlatch #(.BYTE_W(BYTE_W)) u_rdlatch (
        .clk       (clk),
        .rst       (rst),
        .rd_hi     (op.rd_hi),
        .rd_lo     (op.rd_lo),
        .freeze    (dbg_freeze),
        .clear_req (lat_clear),
        .live      (ch_val),
        .rd_byte   (lat_byte)
    );

    cvr_wbuf #(.BYTE_W(BYTE_W)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .wr_hi      (op.wr_hi && wr_ok),
        .wr_lo      (op.wr_lo && wr_ok),
        .wdata      (bus_wdata),
        .cancel     (op.wr_ctrl),
        .immediate  (clk_src == 2'b00),
        .fire       (fire),
        .commit     (commit),
        .commit_val (commit_val)
    );

    cvr_valreg #(.BYTE_W(BYTE_W)) u_valreg (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_val (commit_val),
        .cap_evt    (cap_evt),
        .cap_val    (ctr_now),
        .ctrl_we    (op.wr_ctrl),
        .ctrl_wdata (bus_wdata),
        .val_q      (ch_val),
        .ctrl_q     (ctrl_q),
        .mode       (mode)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.rd_ctrl)               bus_rdata = ctrl_q;
        else if (op.rd_hi || op.rd_lo) bus_rdata = lat_byte;
    end

endmodule

// File: rtl/chanval_coherent_chk.sv
module chanval_coherent_chk #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [1:0]        clk_src,
    input logic              pre_tick,
    input logic [VAL_W-1:0]  ctr_now,
    input logic [VAL_W-1:0]  ctr_mod,
    input logic              dbg_freeze,
    input logic              cap_evt,
    input logic [VAL_W-1:0]  ch_val,
    input logic [1:0]        ch_mode
);

    // R4: a frozen high-byte read shows the live register
    a_r4_freeze_live: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && dbg_freeze && bus_addr == 2'd0)
        |-> bus_rdata == ch_val[VAL_W-1:BYTE_W]);

    // R5: capture mode changes the value only on a strobe
    a_r5_capture_hold: assert property (@(posedge clk) disable iff (rst)
        (ch_mode == 2'b00 && !cap_evt) |=> $stable(ch_val));

    // R6: clock-less compare/PWM needs a bus access or tick to change
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (ch_mode != 2'b00 && clk_src == 2'b00 && !pre_tick && !bus_en)
        |=> $stable(ch_val));

    // R7: clocked compare mode changes only on a tick
    a_r7_compare_tick_only: assert property (@(posedge clk) disable iff (rst)
        (ch_mode[0] && clk_src != 2'b00 && !pre_tick) |=> $stable(ch_val));

    // R8: clocked PWM mode changes only at rollover
    a_r8_pwm_rollover_only: assert property (@(posedge clk) disable iff (rst)
        (ch_mode == 2'b10 && clk_src != 2'b00 && !(pre_tick && ctr_now == ctr_mod))
        |=> $stable(ch_val));

endmodule

bind chanval_coherent chanval_coherent_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .clk_src    (clk_src),
    .pre_tick   (pre_tick),
    .ctr_now    (ctr_now),
    .ctr_mod    (ctr_mod),
    .dbg_freeze (dbg_freeze),
    .cap_evt    (cap_evt),
    .ch_val     (ch_val),
    .ch_mode    (ch_mode)
);

// File: tb/sim_chanval_coherent.sv
module sim_chanval_coherent;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en, bus_wr;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [1:0]  clk_src;
    logic        pre_tick;
    logic [15:0] ctr_now, ctr_mod;
    logic        dbg_freeze, cap_evt;
    logic [15:0] ch_val;
    logic [1:0]  ch_mode;

    always #5 clk = ~clk;

    chanval_coherent u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_src(clk_src), .pre_tick(pre_tick), .ctr_now(ctr_now),
        .ctr_mod(ctr_mod), .dbg_freeze(dbg_freeze), .cap_evt(cap_evt),
        .ch_val(ch_val), .ch_mode(ch_mode)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] last_rd;

    // behavioural reference state
    int m_val, m_ctrl, m_lat, m_buf[2];
    bit m_lv, m_lfh, m_have[2], m_pend;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int exp_rdata(bit en, bit wr, int a);
        int hi_live, lo_live;
        if (!en || wr || a == 3) return 0;
        if (a == 2) return m_ctrl;
        if (dbg_freeze || !m_lv) return (a == 0) ? (m_val >> 8) & 255 : m_val & 255;
        return (a == 0) ? (m_lat >> 8) & 255 : m_lat & 255;
    endfunction

    task automatic model_reset();
        m_val = 0; m_ctrl = 0; m_lat = 0; m_lv = 0; m_lfh = 0;
        m_buf[0] = 0; m_buf[1] = 0; m_have[0] = 0; m_have[1] = 0; m_pend = 0;
    endtask

    task automatic model_step(bit en, bit wr, int a, int d, bit tk, bit cp);
        int mode = m_ctrl & 3;
        int nval = m_val;
        bit vwrite = en && wr && a < 2;
        bit fire = tk && (mode != 2 || ctr_now == ctr_mod);
        if (en && wr && a == 2) begin
            m_ctrl = d; m_lv = 0; m_have[0] = 0; m_have[1] = 0; m_pend = 0;
        end else if (vwrite) begin
            if (dbg_freeze) m_lv = 0;
            if (mode != 0) begin
                int lane = (a == 0) ? 1 : 0;
                m_buf[lane] = d; m_have[lane] = 1; m_pend = 0;
                if (m_have[0] && m_have[1]) begin
                    m_have[0] = 0; m_have[1] = 0;
                    if (clk_src == 0) nval = (m_buf[1] << 8) | m_buf[0];
                    else m_pend = 1;
                end
            end
        end else begin
            if (en && !wr && a < 2 && !dbg_freeze) begin
                bit hi = (a == 0);
                if (!m_lv) begin m_lv = 1; m_lfh = hi; m_lat = m_val; end
                else if (hi != m_lfh) m_lv = 0;
            end
            if (m_pend && fire) begin
                nval = (m_buf[1] << 8) | m_buf[0];
                m_pend = 0;
            end
        end
        if (mode == 0 && cp) nval = ctr_now;
        m_val = nval;
    endtask

    task automatic cyc(bit en, bit wr, int a, int d, bit tk, bit cp);
        bus_en = en; bus_wr = wr; bus_addr = 2'(a); bus_wdata = 8'(d);
        pre_tick = tk; cap_evt = cp;
        #1;
        last_rd = bus_rdata;
        chk("R2/R4 rdata vs model", bus_rdata, exp_rdata(en, wr, a));
        @(posedge clk);
        model_step(en, wr, a, d, tk, cp);
        @(negedge clk);
        bus_en = 0; bus_wr = 0; pre_tick = 0; cap_evt = 0;
        chk("R5/R6/R7/R8/R9 value vs model", ch_val, m_val);
        chk("R3 mode vs model", ch_mode, m_ctrl & 3);
    endtask

    task automatic wr(int a, int d);  cyc(1, 1, a, d, 0, 0); endtask
    task automatic rd(int a);         cyc(1, 0, a, 0, 0, 0); endtask
    task automatic idle(bit tk);      cyc(0, 0, 0, 0, tk, 0); endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_en = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        clk_src = 0; pre_tick = 0; ctr_now = 0; ctr_mod = 0;
        dbg_freeze = 0; cap_evt = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 value after reset", ch_val, 0);
        chk("R1 mode after reset", ch_mode, 0);
        rd(2); chk("R1 control read", last_rd, 0);

        // R6 immediate update, R9 single byte and order
        wr(2, 8'h01);
        wr(0, 8'h12); chk("R9 single byte holds", ch_val, 16'h0000);
        wr(1, 8'h34); chk("R6 immediate commit", ch_val, 16'h1234);
        wr(1, 8'h56); chk("R9 low only holds", ch_val, 16'h1234);
        wr(0, 8'h78); chk("R9 low-then-high pair", ch_val, 16'h7856);

        // R7 compare with clock
        clk_src = 1;
        wr(0, 8'hAB);
        cyc(1, 1, 1, 8'hCD, 1, 0); chk("R7 no commit on completing cycle", ch_val, 16'h7856);
        idle(0); chk("R7 wait for tick", ch_val, 16'h7856);
        idle(1); chk("R7 commit on tick", ch_val, 16'hABCD);

        // R2 coherency
        rd(0); chk("R2 first read live", last_rd, 8'hAB);
        clk_src = 0;
        wr(0, 8'h11); wr(1, 8'h11); chk("R6 commit", ch_val, 16'h1111);
        rd(1); chk("R2 second read latched", last_rd, 8'hCD);
        rd(1); chk("R2 latch emptied", last_rd, 8'h11);

        // R3 control write
        rd(0); chk("R2 latch refill", last_rd, 8'h11);
        wr(0, 8'h22); wr(1, 8'h22);
        wr(2, 8'h01);
        rd(1); chk("R3 latch cleared by control", last_rd, 8'h22);
        rd(0);
        clk_src = 1;
        wr(0, 8'h33); wr(1, 8'h33); wr(2, 8'h01);
        idle(1); chk("R3 waiting pair cancelled", ch_val, 16'h2222);
        wr(0, 8'h44); wr(2, 8'h01);
        clk_src = 0;
        wr(1, 8'h55); chk("R3 half pair cancelled", ch_val, 16'h2222);
        wr(0, 8'h66); chk("R9 pair after cancel", ch_val, 16'h6655);

        // R4 freeze
        rd(0); chk("R2 latch fill", last_rd, 8'h66);
        wr(0, 8'h77); wr(1, 8'h77);
        dbg_freeze = 1;
        rd(1); chk("R4 frozen read live", last_rd, 8'h77);
        dbg_freeze = 0;
        rd(1); chk("R4 latch kept across freeze", last_rd, 8'h55);
        rd(0);
        wr(0, 8'h88); wr(1, 8'h88);
        dbg_freeze = 1;
        wr(1, 8'h99);
        dbg_freeze = 0;
        rd(1); chk("R4 frozen write cleared latch", last_rd, 8'h88);
        rd(0);
        wr(0, 8'hAA); chk("R9 pair across freeze", ch_val, 16'hAA99);

        // R8 PWM rollover
        wr(2, 8'h02); clk_src = 1; ctr_mod = 16'h0010;
        wr(0, 8'h44); wr(1, 8'h44);
        ctr_now = 16'h0005; idle(1); chk("R8 no commit below modulo", ch_val, 16'hAA99);
        ctr_now = 16'h0010; idle(0); chk("R8 no commit without tick", ch_val, 16'hAA99);
        idle(1); chk("R8 commit at rollover", ch_val, 16'h4444);

        // R9 new byte cancels waiting value
        wr(2, 8'h01);
        wr(0, 8'h12); wr(1, 8'h12); wr(0, 8'h34);
        idle(1); chk("R9 waiting value cancelled", ch_val, 16'h4444);
        wr(1, 8'h56); idle(1); chk("R9 restarted pair", ch_val, 16'h3456);

        // R5 capture
        wr(2, 8'h00); clk_src = 0;
        wr(0, 8'h5A); wr(1, 8'h5A); chk("R5 writes ignored", ch_val, 16'h3456);
        ctr_now = 16'h0ABC; cyc(0, 0, 0, 0, 0, 1); chk("R5 capture load", ch_val, 16'h0ABC);
        wr(2, 8'hC1); rd(2); chk("R3 control readback", last_rd, 8'hC1);
        ctr_now = 16'h1111; cyc(0, 0, 0, 0, 0, 1); chk("R5 strobe ignored in compare", ch_val, 16'h0ABC);

        // mixed traffic against the model
        ctr_mod = 16'h0003;
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            if ($urandom_range(0, 29) == 0) clk_src = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 19) == 0) dbg_freeze = ~dbg_freeze;
            ctr_now = 16'($urandom_range(0, 3));
            if (r < 5)       cyc(1, 1, 2, $urandom_range(0, 255), 0, 0);
            else if (r < 40) cyc(1, 1, $urandom_range(0, 1), $urandom_range(0, 255),
                                 $urandom_range(0, 1), $urandom_range(0, 1));
            else if (r < 75) cyc(1, 0, $urandom_range(0, 3), 0,
                                 $urandom_range(0, 1), $urandom_range(0, 1));
            else             cyc(0, 0, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1));
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule